// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two direction predictors side by side. The first is a per-address table of 2-bit saturating counters. The second is a table of 2-bit counters whose index mixes a global record of recent branch outcomes with the branch address. A third table of 2-bit chooser counters is indexed by the address. For each branch it decides which of the two guesses to trust.

The fetch stage presents an address on the lookup port and reads the guess back in the same cycle. When the branch resolves, the pipeline presents the branch address and its real outcome on the training port. Both component tables then train toward the real outcome. The global outcome record shifts the new result in. The chooser for that address moves toward whichever component was right, but only when exactly one of them was right. Capturing branch targets and repairing speculative history are left to other blocks.

Top module: `tourney_pred`

## Requirements
- R1: After reset every counter in all three tables holds 01 and the global outcome record holds zero, so every lookup address predicts not taken.
- R2: The per-address table is indexed by the low IDX_W bits of the address. On a valid update its counter steps up by one for a taken outcome and down by one for a not-taken outcome.
- R3: The history-indexed table is indexed by the global outcome record XOR the low IDX_W bits of the address. Lookup uses the record at lookup time, and training uses the record as it was before that update shifts.
- R4: Each valid update shifts the outcome (1 = taken) into bit 0 of the global outcome record, and the oldest bit is dropped.
- R5: A chooser value of 10 or 11 selects the history-indexed guess; 00 or 01 selects the per-address guess. A component counter predicts taken when its value is 10 or 11.
- R6: The chooser at the update address rises by one when only the history-indexed component was right, falls by one when only the per-address component was right, and holds when both or neither were right.
- R7: All counters saturate at 00 and 11.
- R8: While the update-valid input is low, no table entry and no history bit changes, whatever the other update inputs carry.
- R9: The guess is combinational from the lookup address, and the effect of an update appears on the guess from the cycle after the update edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookPc | input | ADDR_W | Address of the branch being fetched |
| guessTaken | output | 1 | Predicted direction for lookPc (1 = taken) |
| trainValid | input | 1 | Resolved branch is presented this cycle |
| trainPc | input | ADDR_W | Address of the resolved branch |
| trainTaken | input | 1 | Real outcome of the resolved branch (1 = taken) |

## Verification
The bench drives long runs of a single address until the counters pin at 11 and then at 00. A design without saturation would wrap around and flip its guess. It runs patterns where the two components disagree, so a chooser that moves when both agree, or moves the wrong way, steers the guess to the wrong side. It holds the update-valid input low while the outcome toggles, which exposes any table or history write that leaks through. A random mixed stream checks the XOR indexing and the order of the history shift, because a history that is shifted before training, or a shift from the wrong end, soon sends guesses to the wrong entries.

// File: rtl/tourney_pkg.sv
`timescale 1ns/1ps
package tourney_pkg;

  typedef struct packed {
    logic trainEn;    // write both component counters
    logic dirTaken;   // direction to train toward
    logic chooseUp;   // chooser toward history-indexed side
    logic chooseDown; // chooser toward per-address side
    logic histShift;  // shift outcome into global record
  } ctlStrobes_t;

  function automatic logic [1:0] satInc(input logic [1:0] v);
    return (v == 2'b11) ? v : v + 2'b01;
  endfunction

  function automatic logic [1:0] satDec(input logic [1:0] v);
    return (v == 2'b00) ? v : v - 2'b01;
  endfunction

endpackage

// File: rtl/tourney_ctl.sv
`timescale 1ns/1ps
module tourney_ctl
  import tourney_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trainValid,
  input  logic        trainTaken,
  input  logic        bimAtTrain,
  input  logic        gloAtTrain,
  output ctlStrobes_t ctl
);

  logic bimRight, gloRight;

  always_comb begin
    bimRight = (bimAtTrain == trainTaken);
    gloRight = (gloAtTrain == trainTaken);
    ctl.trainEn    = trainValid;
    ctl.dirTaken   = trainTaken;
    ctl.histShift  = trainValid;
    ctl.chooseUp   = trainValid && gloRight && !bimRight;
    ctl.chooseDown = trainValid && bimRight && !gloRight;
  end

  // R6: the chooser never moves both ways
  p_choose_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.chooseUp && ctl.chooseDown));

  // R6: agreeing components leave the chooser alone
  p_choose_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bimAtTrain == gloAtTrain) |-> !(ctl.chooseUp || ctl.chooseDown));

  // R8: no strobe without a valid update
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !trainValid |-> !(ctl.trainEn || ctl.histShift || ctl.chooseUp || ctl.chooseDown));

endmodule

// File: rtl/tourney_dp.sv
`timescale 1ns/1ps
module tourney_dp
  import tourney_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lookIdx,
  input  logic [IDX_W-1:0] trainIdx,
  input  ctlStrobes_t      ctl,
  output logic             guessTaken,
  output logic             bimAtTrain,
  output logic             gloAtTrain
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int HIST_W  = IDX_W;

  logic [1:0] bimTab [ENTRIES];
  logic [1:0] gloTab [ENTRIES];
  logic [1:0] chsTab [ENTRIES];
  logic [HIST_W-1:0] globHist;

  logic [IDX_W-1:0] lookGIdx, trainGIdx;

  always_comb begin
    lookGIdx   = lookIdx ^ globHist;
    trainGIdx  = trainIdx ^ globHist;
    guessTaken = chsTab[lookIdx][1] ? gloTab[lookGIdx][1] : bimTab[lookIdx][1];
    bimAtTrain = bimTab[trainIdx][1];
    gloAtTrain = gloTab[trainGIdx][1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        bimTab[i] <= 2'b01;
        gloTab[i] <= 2'b01;
        chsTab[i] <= 2'b01;
      end
      globHist <= '0;
    end else begin
      if (ctl.trainEn) begin
        bimTab[trainIdx]  <= ctl.dirTaken ? satInc(bimTab[trainIdx])  : satDec(bimTab[trainIdx]);
        gloTab[trainGIdx] <= ctl.dirTaken ? satInc(gloTab[trainGIdx]) : satDec(gloTab[trainGIdx]);
      end
      if (ctl.chooseUp)
        chsTab[trainIdx] <= satInc(chsTab[trainIdx]);
      else if (ctl.chooseDown)
        chsTab[trainIdx] <= satDec(chsTab[trainIdx]);
      if (ctl.histShift)
        globHist <= {globHist[HIST_W-2:0], ctl.dirTaken};
    end
  end

  // R4: newest outcome lands in bit 0, older bits move up
  p_hist_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.histShift |=> (globHist[0] == $past(ctl.dirTaken)) &&
                      (globHist[HIST_W-1:1] == $past(globHist[HIST_W-2:0])));

  // R8: history holds without a shift strobe
  p_hist_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.histShift |=> $stable(globHist));

endmodule

// File: rtl/tourney_pred.sv
`timescale 1ns/1ps
module tourney_pred
  import tourney_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lookPc,
  output logic              guessTaken,
  input  logic              trainValid,
  input  logic [ADDR_W-1:0] trainPc,
  input  logic              trainTaken
);

  ctlStrobes_t ctl;
  logic bimAtTrain, gloAtTrain;

  tourney_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trainValid (trainValid),
    .trainTaken (trainTaken),
    .bimAtTrain (bimAtTrain),
    .gloAtTrain (gloAtTrain),
    .ctl        (ctl)
  );

  tourney_dp #(.IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .lookIdx    (lookPc[IDX_W-1:0]),
    .trainIdx   (trainPc[IDX_W-1:0]),
    .ctl        (ctl),
    .guessTaken (guessTaken),
    .bimAtTrain (bimAtTrain),
    .gloAtTrain (gloAtTrain)
  );

  logic unusedHigh;
  assign unusedHigh = ^{lookPc[ADDR_W-1:IDX_W], trainPc[ADDR_W-1:IDX_W]};

endmodule

// File: tb/tb_tourney_pred.sv
`timescale 1ns/1ps
module tb_tourney_pred;

  localparam int ADDR_W = 16;
  localparam int IDX_W  = 6;
  localparam int N      = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] lookPc = '0;
  logic guessTaken;
  logic trainValid = 1'b0;
  logic [ADDR_W-1:0] trainPc = '0;
  logic trainTaken = 1'b0;

  always #4 clk = ~clk;

  tourney_pred #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .lookPc(lookPc), .guessTaken(guessTaken),
    .trainValid(trainValid), .trainPc(trainPc), .trainTaken(trainTaken)
  );

  // reference model built from the requirements
  logic [1:0] mBim [N];
  logic [1:0] mGlo [N];
  logic [1:0] mChs [N];
  logic [IDX_W-1:0] mHist;

  typedef struct { bit exp; string tag; } item_t;
  item_t sbQ[$];

  int applied = 0;
  int miscompares = 0;
  bit doneFlag = 0;

  function automatic bit modelGuess(input logic [ADDR_W-1:0] pc);
    logic [IDX_W-1:0] i;
    i = pc[IDX_W-1:0];
    return mChs[i][1] ? mGlo[i ^ mHist][1] : mBim[i][1];  // R5
  endfunction

  function automatic logic [1:0] up2(input logic [1:0] v);
    return (v == 2'b11) ? v : v + 2'b01;
  endfunction
  function automatic logic [1:0] dn2(input logic [1:0] v);
    return (v == 2'b00) ? v : v - 2'b01;
  endfunction

  task automatic modelTrain(input logic [ADDR_W-1:0] pc, input bit t);
    logic [IDX_W-1:0] i, g;
    bit bOk, gOk;
    i = pc[IDX_W-1:0];
    g = i ^ mHist;                              // R3
    bOk = (mBim[i][1] == t);
    gOk = (mGlo[g][1] == t);
    mBim[i] = t ? up2(mBim[i]) : dn2(mBim[i]);   // R2, R7
    mGlo[g] = t ? up2(mGlo[g]) : dn2(mGlo[g]);
    if (gOk && !bOk) mChs[i] = up2(mChs[i]);     // R6
    else if (bOk && !gOk) mChs[i] = dn2(mChs[i]);
    mHist = {mHist[IDX_W-2:0], t};               // R4
  endtask

  // driver: one cycle of stimulus, expected guess pushed to the scoreboard
  task automatic drive(input logic [ADDR_W-1:0] lp, input bit v,
                       input logic [ADDR_W-1:0] tp, input bit t, input string tag);
    item_t it;
    @(negedge clk);
    lookPc = lp; trainValid = v; trainPc = tp; trainTaken = t;
    it.exp = modelGuess(lp);
    it.tag = tag;
    sbQ.push_back(it);
    if (v) modelTrain(tp, t);
  endtask

  // monitor: compares away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sbQ.size() > 0) begin
        item_t it;
        it = sbQ.pop_front();
        applied++;
        if (guessTaken !== it.exp) begin
          miscompares++;
          $display("FAIL %s: guess got %0b expected %0b", it.tag, guessTaken, it.exp);
        end
      end
    end
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      miscompares++;
      $display("FAIL watchdog: got hung expected completion");
      finishRun();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin mBim[i] = 2'b01; mGlo[i] = 2'b01; mChs[i] = 2'b01; end
    mHist = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state predicts not taken everywhere
    for (int a = 0; a < N; a += 7) drive(a[ADDR_W-1:0], 1'b0, '0, 1'b0, "R1 reset");

    // R2 / R7: drive one address taken until saturated, then back down
    for (int k = 0; k < 6; k++) drive(16'h0005, 1'b1, 16'h0005, 1'b1, "R2 train up");
    drive(16'h0005, 1'b0, '0, 1'b0, "R7 saturated high");
    drive(16'h0045, 1'b0, '0, 1'b0, "R2 upper bits ignored");
    for (int k = 0; k < 7; k++) drive(16'h0005, 1'b1, 16'h0005, 1'b0, "R7 train down");
    drive(16'h0005, 1'b0, '0, 1'b0, "R9 visible after edge");

    // R8: invalid updates with toggling outcome change nothing
    for (int k = 0; k < 10; k++)
      drive(16'h0005 ^ k[ADDR_W-1:0], 1'b0, 16'h0005 ^ k[ADDR_W-1:0], k[0], "R8 idle");

    // R6 / R5: alternating pattern makes components disagree
    for (int k = 0; k < 40; k++) drive(16'h0011, 1'b1, 16'h0011, k[0], "R6 alternating");
    for (int k = 0; k < 30; k++) drive(16'h0022, 1'b1, 16'h0022, (k % 3) != 0, "R5 period three");

    // R3 / R4: random mixed stream over a few hot addresses
    for (int k = 0; k < 3000; k++) begin
      logic [ADDR_W-1:0] p;
      bit v, t;
      p = ADDR_W'($urandom_range(0, 11)) * 16'd5;
      v = ($urandom_range(0, 3) != 0);
      t = (p[2] ^ mHist[1]) ? 1'b1 : ($urandom_range(0, 4) == 0);
      drive(ADDR_W'($urandom_range(0, 63)), v, p, t, "R3 R4 random");
    end
    drive('0, 1'b0, '0, 1'b0, "R9 drain");
    @(negedge clk); #2;
    doneFlag = 1;
    finishRun();
  end

endmodule